// File: doc/BRIEF.md
# Hysteretic Charge Pump Gate Control

This block drives the switching input of an external charge pump that lifts the gate of a high-side N-channel pass switch above the supply rail. A free-running oscillator gives an asymmetric square wave, a long high phase and a short low phase. The low phase gives the pump time to recharge its flying capacitor. The oscillator output is registered and sent to the pump only while a current limit allows it.

The current limit depends on where the load voltage sits. With the load still well below its final level, the pump runs only under the low current trip. Between the two load thresholds it runs under the high current trip. Above the upper load threshold, current gating is dropped. When the active trip is exceeded the pump stops and the gate charge bleeds away. The pump restarts as soon as the current falls back under the trip, so inrush is held in a hysteretic band and the switch stays inside its safe operating area. A sequencer enables the block. When the enable is withdrawn, the output is held low and the oscillator restarts from the beginning of its high phase.

Top module: `hsw_pump_gate`

## Requirements
- R1: While `rst` is high at a rising edge, `pump` is 0 after that edge, and all internal comparator sync stages read as 0.
- R2: With the current limit open, `pump` follows an oscillator. It is 1 for HIGH_CYC = (CLK_HZ/1e6)*HIGH_NS/1000 outputs, then 0 for LOW_CYC = (CLK_HZ/1e6)*LOW_NS/1000 outputs, repeating. The first rising edge with `en` high starts a high phase.
- R3: While the synchronized `load_lo` and `load_hi` are both 0, `pump` is 0 whenever the synchronized `cur_lo` is 1. `cur_hi` has no effect in this regime.
- R4: While the synchronized `load_lo` is 1 and `load_hi` is 0, `pump` is 0 whenever the synchronized `cur_hi` is 1. `cur_lo` has no effect in this regime.
- R5: While the synchronized `load_hi` is 1, both current flags are ignored, and `pump` follows the oscillator alone.
- R6: A rising edge with `en` low sets `pump` to 0 and clears the oscillator. The next enabled edge starts a fresh high phase.
- R7: Every comparator flag passes through two flops. A flag sampled at rising edge k first affects `pump` after edge k+2. Once the trip flag clears, the pump resumes in the running oscillator phase with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sequencer enable for the pump |
| load_lo | input | 1 | Load voltage above the lower threshold (asynchronous) |
| load_hi | input | 1 | Load voltage above the upper threshold (asynchronous) |
| cur_lo | input | 1 | Current above the low trip point (asynchronous) |
| cur_hi | input | 1 | Current above the high trip point (asynchronous) |
| pump | output | 1 | Registered charge pump drive |

## Verification
The bench targets the regime boundaries. Each current flag is set while the other regime is active, to expose a design that decodes the wrong trip for a load region. Upper-regime stimulus holds both current flags high, which catches a design that keeps limiting once the load is up. Flags change one or two cycles before an oscillator phase edge and right after a trip clears. These cases catch a wrong synchronizer depth and a pump that waits for a new period before it resumes. Enable drops in mid-phase and reset is applied mid-run; a design that keeps its count would restart in the wrong phase.

// File: rtl/hsw_pump_gate.sv
module hsw_pump_gate #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int HIGH_NS = 32000,
  parameter int LOW_NS  = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic load_lo,
  input  logic load_hi,
  input  logic cur_lo,
  input  logic cur_hi,
  output logic pump
);
  localparam int MHZ      = CLK_HZ / 1_000_000;
  localparam int HIGH_CYC = (MHZ * HIGH_NS) / 1000;
  localparam int LOW_CYC  = (MHZ * LOW_NS) / 1000;
  localparam int MAX_CYC  = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int CW       = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic [3:0]    meta, flg;
  logic [CW-1:0] cnt;
  logic          ext;
  logic          ld_lo, ld_hi, ov_lo, ov_hi, limit_ok, last;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      flg  <= '0;
    end else begin
      meta <= {load_hi, load_lo, cur_hi, cur_lo};
      flg  <= meta;
    end
  end

  assign {ld_hi, ld_lo, ov_hi, ov_lo} = flg;

  assign limit_ok = ld_hi | (ld_lo & ~ov_hi) | (~ld_lo & ~ov_lo);
  assign last     = ext ? (cnt == CW'(LOW_CYC - 1)) : (cnt == CW'(HIGH_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      ext <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      ext <= ~ext;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) pump <= 1'b0;
    else            pump <= ~ext & limit_ok;
  end
endmodule

// File: rtl/hsw_pump_gate_chk.sv
module hsw_pump_gate_chk #(
  parameter int LOW_CYC = 800
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic load_lo,
  input logic load_hi,
  input logic cur_lo,
  input logic cur_hi,
  input logic ext,
  input logic pump
);
  logic [2:0] since;
  int         lowrun;

  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 3'd7) since <= since + 1'b1;
    if (rst || !ext) lowrun <= 0;
    else             lowrun <= lowrun + 1;
  end

  assert_reset_low_R1: assert property (@(posedge clk) rst |=> !pump);

  assert_low_phase_R2: assert property (@(posedge clk) disable iff (rst)
    ext |=> !pump);

  assert_low_phase_len_R2: assert property (@(posedge clk) disable iff (rst)
    ext |-> (lowrun < LOW_CYC));

  assert_low_region_limit_R3: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd4 && !$past(load_lo, 3) && !$past(load_hi, 3) && $past(cur_lo, 3)) |-> !pump);

  assert_mid_region_limit_R4: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd4 && $past(load_lo, 3) && !$past(load_hi, 3) && $past(cur_hi, 3)) |-> !pump);

  assert_high_region_free_R5: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd4 && $past(load_hi, 3) && $past(en) && !$past(ext)) |-> pump);

  assert_disable_low_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pump && !ext));
endmodule

bind hsw_pump_gate hsw_pump_gate_chk #(.LOW_CYC(LOW_CYC)) u_chk (
  .clk(clk), .rst(rst), .en(en), .load_lo(load_lo), .load_hi(load_hi),
  .cur_lo(cur_lo), .cur_hi(cur_hi), .ext(ext), .pump(pump)
);

// File: tb/test_hsw_pump_gate.sv
module test_hsw_pump_gate;
  localparam int H = 32;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic load_lo = 1'b0, load_hi = 1'b0, cur_lo = 1'b0, cur_hi = 1'b0;
  logic pump;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  hsw_pump_gate #(.CLK_HZ(250_000_000), .HIGH_NS(128), .LOW_NS(32)) i_hsw_pump_gate (
    .clk(clk), .rst(rst), .en(en), .load_lo(load_lo), .load_hi(load_hi),
    .cur_lo(cur_lo), .cur_hi(cur_hi), .pump(pump)
  );

  always #2 clk = ~clk;

  // bench model: flags as {load_hi, load_lo, cur_hi, cur_lo}
  logic [3:0] h1 = '0, h2 = '0, h0 = '0;
  int ph = 0;
  logic exp_p = 1'b0;
  string tag = "R1";

  function automatic logic limit_open(input logic [3:0] f);
    if (f[3]) return 1'b1;
    if (f[2]) return !f[1];
    return !f[0];
  endfunction

  function automatic string pick_tag(input logic r, input logic e, input int p,
                                     input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    if (r) return "R1";
    if (!e) return "R6";
    if (p >= H) return "R2";
    if (a != b || b != c) return "R7";
    if (c[3]) return "R5";
    if (c[2]) return "R4";
    return "R3";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      h0 <= '0; h1 <= '0; h2 <= '0; ph <= 0; exp_p <= 1'b0; tag <= "R1";
    end else begin
      h0 <= {load_hi, load_lo, cur_hi, cur_lo};
      h1 <= {load_hi, load_lo, cur_hi, cur_lo};
      h2 <= h1;
      tag <= pick_tag(1'b0, en, ph, h0, h1, h2);
      if (!en) begin
        ph <= 0; exp_p <= 1'b0;
      end else begin
        exp_p <= (ph < H) && limit_open(h2);
        ph <= (ph + 1) % (H + L);
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      n_run++;
      if (pump !== exp_p) begin
        n_fail++;
        $display("FAIL %s: pump=%b expected=%b at %0t", tag, pump, exp_p, $time);
      end
    end
  end

  task automatic drive(input logic e, input logic [3:0] f, input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      en = e;
      {load_hi, load_lo, cur_hi, cur_lo} = f;
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5A17);
    drive(1'b0, 4'b0000, 5);            // R1 reset state
    @(negedge clk); rst = 1'b0;
    drive(1'b1, 4'b0000, 2 * (H + L));  // R2 free oscillation, R3 open
    drive(1'b1, 4'b0001, 30);           // R3 low trip, low load
    drive(1'b1, 4'b0010, 30);           // R3 high trip ignored at low load
    drive(1'b1, 4'b0101, 30);           // R4 low trip ignored mid load
    drive(1'b1, 4'b0110, 30);           // R4 high trip stops pump
    drive(1'b1, 4'b0100, 3);            // R7 immediate resume
    drive(1'b1, 4'b1111, 2 * (H + L));  // R5 current ignored
    drive(1'b1, 4'b1011, H + L);        // R5 with load_lo clear
    drive(1'b1, 4'b0000, H - 2);        // R7 flag edge near phase change
    drive(1'b1, 4'b0001, 4);
    drive(1'b0, 4'b0000, 7);            // R6 mid-phase disable
    drive(1'b1, 4'b0000, H + L + 5);
    @(negedge clk); rst = 1'b1;         // R1 mid-run reset
    drive(1'b1, 4'b1111, 3);
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 600; k++) begin
      logic [3:0] f;
      logic e;
      f = 4'($urandom);
      e = ($urandom % 12) != 0;
      drive(e, f, 1 + ($urandom % 12));
    end
    @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule